// File: doc/BRIEF.md
# Supply Undervoltage Filter and Status Register

This block is the digital back end of a supply-voltage monitor. Two analog comparators feed it. One reports that the supply has dropped under the trip threshold. The other reports that the supply has climbed above the recovery threshold, which is the trip threshold plus a hysteresis margin. Both signals are resynchronised to the oscillator clock.

The trip indication then passes through a run-length filter. Only a sustained dip raises a sticky undervoltage flag. The flag clears once the supply is back above the recovery level. While the supply sits between the two levels, the flag keeps its last value.

An eight-bit status/control register exposes the flag as read-only. The register also holds a writable threshold-select bit that steers the analog reference pair. A configuration input gates the whole filter. When that input is high, the filter keeps running even while the core sits in its low-power wait state. When it is low, the filter is parked and the flag is frozen. The block raises no interrupt.

Top module: `lvd_monitor`

## Requirements
- R1: After reset the register reads 8'h00 (flag clear, threshold-select clear) and `tightThreshold` is 0.
- R2: If `belowTrip` is sampled high on fewer than SET_COUNT (36) consecutive rising edges, the flag (register bit 7) stays 0.
- R3: If `belowTrip` is sampled high on SET_COUNT (36) or more consecutive rising edges, the flag becomes 1. It is visible after the 38th rising edge, counting from the first edge that samples `belowTrip` high (two synchronizer stages plus the flag register), and not after the 37th.
- R4: With `monitorEnable` high, `aboveRecover` sampled high while `belowTrip` is low clears the flag. The flag reads 0 after the third rising edge that samples it and still reads 1 after the second.
- R5: While both comparator inputs are low (hysteresis band), the flag keeps its previous value, whether that value is 0 or 1.
- R6: A single edge that samples `belowTrip` low restarts the run count. Two runs that total 36 or more edges but are each shorter than 36 leave the flag at 0.
- R7: While `monitorEnable` is 0, the flag is frozen and the run count is held at zero. It is neither set by a long dip nor cleared by `aboveRecover`, and counting restarts from zero when the input returns to 1.
- R8: A register write with `regWrEn` high loads bit 0 of `regWrData` into the threshold-select bit. Bit 0 drives `tightThreshold`: 1 selects the tight (5 %) level pair, 0 selects the loose (10 %) pair.
- R9: Writes to bits 7..1 have no effect, and bits 6..1 always read 0.
- R10: Once set by a dip of any length (the count saturates), the flag stays 1 until a recovery indication. This includes after `belowTrip` falls back into the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| belowTrip | input | 1 | Comparator: supply under trip level (asynchronous) |
| aboveRecover | input | 1 | Comparator: supply above recovery level (asynchronous) |
| monitorEnable | input | 1 | Configuration: filter active, including in wait state |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data {flag, 6'b0, threshold-select} |
| tightThreshold | output | 1 | Threshold pair select to the analog side |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and a set count of 36, which gives a six-bit counter. These values are small enough that every dip length from 1 to 45 edges can be swept. That sweep covers both sides of the set point exactly, and the expected flag is computed arithmetically from the length. The same configuration puts the 37-versus-38-edge latency boundary and the recovery latency within a few cycles. Register-write patterns and enable gating are checked against the same arithmetic model.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int SEL_BIT  = 0;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } lvd_strobe_t;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[gi] <= '0;
          else        stage[gi] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[gi] <= '0;
          else        stage[gi] <= stage[gi-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
  import lvd_pkg::*;
#(
  parameter int SET_COUNT = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        syncBelow,
  input  logic        syncAbove,
  input  logic        monitorEnable,
  output lvd_strobe_t strobe
);
  localparam int CNT_W = $clog2(SET_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SET_COUNT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SET_COUNT - 1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     runCnt <= '0;
    else if (!monitorEnable)        runCnt <= '0;
    else if (!syncBelow)            runCnt <= '0;
    else if (runCnt != CNT_MAX)     runCnt <= runCnt + 1'b1;
  end

  always_comb begin
    strobe.setFlag = monitorEnable && syncBelow && (runCnt == CNT_LAST);
    strobe.clrFlag = monitorEnable && syncAbove && !syncBelow;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    runCnt <= CNT_MAX);                                            // R10
  AST_PWR_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !monitorEnable |=> runCnt == '0);                              // R7
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !syncBelow |=> runCnt == '0);                                  // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.setFlag && strobe.clrFlag));                          // R4
endmodule

// File: rtl/lvd_dp.sv
module lvd_dp
  import lvd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lvd_strobe_t      strobe,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             tightThreshold
);
  logic lowFlag;
  logic selBit;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:SEL_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lowFlag <= 1'b0;
    else if (strobe.setFlag) lowFlag <= 1'b1;
    else if (strobe.clrFlag) lowFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       selBit <= 1'b0;
    else if (regWrEn) selBit <= regWrData[SEL_BIT];
  end

  always_comb begin
    regRdData           = '0;
    regRdData[FLAG_BIT] = lowFlag;
    regRdData[SEL_BIT]  = selBit;
  end
  assign tightThreshold = selBit;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.setFlag || strobe.clrFlag) |=> $stable(lowFlag));     // R5
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowFlag) |-> $past(strobe.setFlag));                     // R3
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !regWrEn |=> $stable(tightThreshold));                         // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[FLAG_BIT-1:SEL_BIT+1] == '0);                        // R9
endmodule

// File: rtl/lvd_monitor.sv
module lvd_monitor
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SET_COUNT   = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       belowTrip,
  input  logic       aboveRecover,
  input  logic       monitorEnable,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       tightThreshold
);
  logic [1:0]  syncOut;
  lvd_strobe_t strobe;

  lvd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({aboveRecover, belowTrip}),
    .dout  (syncOut)
  );

  lvd_ctrl #(.SET_COUNT(SET_COUNT)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .syncBelow     (syncOut[0]),
    .syncAbove     (syncOut[1]),
    .monitorEnable (monitorEnable),
    .strobe        (strobe)
  );

  lvd_dp u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .regWrEn        (regWrEn),
    .regWrData      (regWrData),
    .regRdData      (regRdData),
    .tightThreshold (tightThreshold)
  );
endmodule

// File: tb/tb_lvd_monitor.sv
module tb_lvd_monitor;
  localparam int SET_N = 36;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       belowTrip = 1'b0;
  logic       aboveRecover = 1'b0;
  logic       monitorEnable = 1'b1;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       tightThreshold;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lvd_monitor dut (
    .clk(clk), .rst_n(rst_n), .belowTrip(belowTrip), .aboveRecover(aboveRecover),
    .monitorEnable(monitorEnable), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .tightThreshold(tightThreshold)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic dip(input int n);
    belowTrip = 1'b1;
    waitEdges(n);
    belowTrip = 1'b0;
    waitEdges(4);
  endtask

  task automatic recover();
    aboveRecover = 1'b1;
    waitEdges(4);
    aboveRecover = 1'b0;
    waitEdges(3);
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    waitEdges(1);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  initial begin
    waitEdges(3);
    // R1: reset state
    check("R1 rd", regRdData, 8'h00);
    check("R1 sel", {7'b0, tightThreshold}, 8'h00);
    rst_n = 1'b1;
    waitEdges(2);
    check("R1 after release", regRdData, 8'h00);

    // R2 / R3: sweep of dip lengths, expected flag = (n >= SET_N)
    for (int n = 1; n <= 45; n++) begin
      dip(n);
      check(n >= SET_N ? "R3 sweep" : "R2 sweep", {7'b0, regRdData[7]},
            {7'b0, (n >= SET_N) ? 1'b1 : 1'b0});
      // R5: flag held in band after the dip
      waitEdges(5);
      check("R5 band hold", {7'b0, regRdData[7]}, {7'b0, (n >= SET_N) ? 1'b1 : 1'b0});
      recover();
      check("R4 recover", {7'b0, regRdData[7]}, 8'h00);
    end

    // R3: latency boundary
    belowTrip = 1'b1;
    waitEdges(37);
    check("R3 not after 37", {7'b0, regRdData[7]}, 8'h00);
    waitEdges(1);
    check("R3 after 38", {7'b0, regRdData[7]}, 8'h01);
    // R10: long dip, saturation, stays set in band
    waitEdges(200);
    check("R10 long dip", {7'b0, regRdData[7]}, 8'h01);
    belowTrip = 1'b0;
    waitEdges(20);
    check("R10 band after long", {7'b0, regRdData[7]}, 8'h01);

    // R4: recovery latency
    aboveRecover = 1'b1;
    waitEdges(2);
    check("R4 still set at 2", {7'b0, regRdData[7]}, 8'h01);
    waitEdges(1);
    check("R4 cleared at 3", {7'b0, regRdData[7]}, 8'h00);
    aboveRecover = 1'b0;
    waitEdges(3);

    // R6: interrupted runs
    belowTrip = 1'b1; waitEdges(30);
    belowTrip = 1'b0; waitEdges(1);
    belowTrip = 1'b1; waitEdges(30);
    belowTrip = 1'b0; waitEdges(4);
    check("R6 restart", {7'b0, regRdData[7]}, 8'h00);

    // R7: disabled monitor ignores long dip
    monitorEnable = 1'b0;
    dip(60);
    check("R7 no set when off", {7'b0, regRdData[7]}, 8'h00);
    // R7: count restarts from zero on re-enable
    belowTrip = 1'b1; waitEdges(30);
    monitorEnable = 1'b1; waitEdges(30);
    belowTrip = 1'b0; waitEdges(4);
    check("R7 restart count", {7'b0, regRdData[7]}, 8'h00);
    // R7: disabled monitor ignores recovery
    dip(40);
    monitorEnable = 1'b0;
    recover();
    check("R7 frozen set", {7'b0, regRdData[7]}, 8'h01);
    monitorEnable = 1'b1;
    recover();
    check("R7 clears after enable", {7'b0, regRdData[7]}, 8'h00);

    // R8 / R9: register writes
    writeReg(8'hFF);
    check("R8 write ff", regRdData, 8'h01);
    check("R8 tight", {7'b0, tightThreshold}, 8'h01);
    writeReg(8'hFE);
    check("R8 write fe", regRdData, 8'h00);
    check("R8 loose", {7'b0, tightThreshold}, 8'h00);
    writeReg(8'h80);
    check("R9 flag not writable", regRdData, 8'h00);
    dip(40);
    writeReg(8'h00);
    check("R9 flag survives write", regRdData, 8'h80);
    writeReg(8'h7F);
    check("R9 reserved read 0", regRdData, 8'h81);
    check("R8 sel again", {7'b0, tightThreshold}, 8'h01);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule